// File: doc/BRIEF.md
# 64b/66b Receive Block Order Guard

This block sits after 64b/66b block alignment on the receive side. Each clock it accepts one 66-bit block together with a class code computed upstream: idle/control, start, data, terminate or invalid. It presents each block toward the MAC one clock later. During that clock it checks the held block against the class of the block that arrives next. If the pair of classes is not a legal packet ordering, the block on the output is replaced with a fixed error block.

A terminate block therefore reaches the output only after the following block has been seen to be a clean idle/control block. If that block is anything else, the terminate is swapped for an error block. This kills the packet that precedes it. The machine then stays in an error state until a clean idle/control block arrives while block lock is reported, so a start block is never taken unless an idle/control block came before it. Loss of block lock forces the error state at once. There is no separate initialisation state: reset enters the error state. The octet decode tables are outside this block. Block payloads pass through unchanged, with a data/control flag and an error flag.

Top module: `blk_order_guard`

## Requirements
- R1: While reset is asserted and after it is released, the state is the error state. The output shows the error block with `out_err`=1 and `out_ctl`=1 until a block is accepted.
- R2: The error state is left for the idle/control state only on a clock where `lock_ok`=1 and the incoming class is Z (code 0). That block is output one clock later, provided the block after it forms a legal pair with it.
- R3: On any clock with `lock_ok`=0, the state becomes the error state and the held block is output as the error block on the next clock.
- R4: The legal class pairs are Z→Z, Z→S, S→D, S→T, D→D, D→T and T→Z. For a legal pair, the block received one clock earlier is output unchanged with `out_err`=0, with `out_ctl`=0 for a data block and `out_ctl`=1 otherwise.
- R5: A held terminate block (code 3) whose successor is not Z is replaced by the error block. The successor is also output as an error block on the following clock.
- R6: In the error state, every output block is the error block. The state stays there on every clock whose incoming class is not Z.
- R7: A start block (code 1) that follows any accepted block other than Z is treated as an illegal pair. The held block and the start block are both output as error blocks.
- R8: Any other pair outside the legal list replaces the held block with the error block and enters the error state. Class codes 4 to 7 all count as invalid (E).
- R9: The error block has header bits [1:0]=2'b01, type byte bits [9:2]=8'h1E, and 8'hFE in each of the remaining seven octet lanes (bits [8k+9:8k+2], k=1..7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one block per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_ok | input | 1 | Block lock achieved by the upstream aligner |
| blk_in | input | 66 | Incoming aligned 66-bit block |
| cls_in | input | 3 | Class of `blk_in`: 0=Z, 1=S, 2=D, 3=T, 4..7=E |
| out_blk | output | 66 | Block presented toward the MAC, one clock behind |
| out_ctl | output | 1 | 1 for a control-type block, 0 for data |
| out_err | output | 1 | 1 when `out_blk` is the substituted error block |

## Verification
Every result appears after the clock edge that follows the clock on which the block's successor is presented. A block driven on edge k is therefore judged and shown after edge k+1, and a state change caused on edge k shows as an error output after edge k+1. The bench drives inputs at the falling edge and runs a reference model of the ordering rules in step with the inputs. It compares the outputs at the next falling edge, exactly one register stage after the judging edge. The kill of the successor in R5 and R7 is checked one further clock later, through the same per-cycle comparison.

// File: rtl/bog_pkg.sv
package bog_pkg;

   typedef enum logic [2:0] {
      CLS_Z = 3'd0,
      CLS_S = 3'd1,
      CLS_D = 3'd2,
      CLS_T = 3'd3,
      CLS_E = 3'd4
   } blk_cls_e;

   // Fold raw class codes: anything above T counts as invalid
   function automatic blk_cls_e norm_cls(input logic [2:0] raw);
      case (raw)
         3'd0:    return CLS_Z;
         3'd1:    return CLS_S;
         3'd2:    return CLS_D;
         3'd3:    return CLS_T;
         default: return CLS_E;
      endcase
   endfunction

   // Allowed successor of an accepted block class
   function automatic logic pair_ok(input blk_cls_e prev, input blk_cls_e nxt);
      case (prev)
         CLS_Z:   return (nxt == CLS_Z) || (nxt == CLS_S);
         CLS_S:   return (nxt == CLS_D) || (nxt == CLS_T);
         CLS_D:   return (nxt == CLS_D) || (nxt == CLS_T);
         CLS_T:   return (nxt == CLS_Z);
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/bog_fsm.sv
module bog_fsm
   import bog_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     lock_ok,
   input  blk_cls_e cls_n,
   output blk_cls_e st_q,
   output logic     kill
);

   blk_cls_e st_d;

   always_comb begin
      st_d = st_q;
      if (!lock_ok) begin
         st_d = CLS_E;
      end else if (st_q == CLS_E) begin
         st_d = (cls_n == CLS_Z) ? CLS_Z : CLS_E;
      end else begin
         st_d = pair_ok(st_q, cls_n) ? cls_n : CLS_E;
      end
   end

   // The held block is dropped if it was never accepted or its successor breaks the order
   assign kill = (st_q == CLS_E) || (st_d == CLS_E);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= CLS_E;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/bog_outreg.sv
module bog_outreg
   import bog_pkg::*;
#(
   parameter int              BLK_W   = 66,
   parameter logic [BLK_W-1:0] ERR_PAT = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BLK_W-1:0] blk_in,
   input  blk_cls_e         cls_n,
   input  logic             kill,
   output blk_cls_e         held_cls,
   output logic [BLK_W-1:0] out_blk,
   output logic             out_ctl,
   output logic             out_err
);

   logic [BLK_W-1:0] held_blk;

   // One block of lookahead: the block is parked here while its successor is judged
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_blk <= '0;
         held_cls <= CLS_E;
      end else begin
         held_blk <= blk_in;
         held_cls <= cls_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_blk <= ERR_PAT;
         out_ctl <= 1'b1;
         out_err <= 1'b1;
      end else if (kill) begin
         out_blk <= ERR_PAT;
         out_ctl <= 1'b1;
         out_err <= 1'b1;
      end else begin
         out_blk <= held_blk;
         out_ctl <= (held_cls != CLS_D);
         out_err <= 1'b0;
      end
   end

endmodule

// File: rtl/blk_order_guard.sv
module blk_order_guard
   import bog_pkg::*;
#(
   parameter int LANES    = 8,
   parameter int LANE_W   = 8,
   parameter int HDR_W    = 2,
   parameter int BLK_W    = 66,
   parameter int CTL_HDR  = 1,
   parameter int ERR_TYPE = 'h1E,
   parameter int ERR_CODE = 'hFE
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lock_ok,
   input  logic [BLK_W-1:0] blk_in,
   input  logic [2:0]       cls_in,
   output logic [BLK_W-1:0] out_blk,
   output logic             out_ctl,
   output logic             out_err
);

   // Header, then a type octet, then a fill code in every other lane
   function automatic logic [BLK_W-1:0] mk_err_pat();
      logic [BLK_W-1:0] v;
      v = '0;
      v[HDR_W-1:0] = CTL_HDR[HDR_W-1:0];
      for (int l = 0; l < LANES; l++) begin
         v[HDR_W + l*LANE_W +: LANE_W] = (l == 0) ? ERR_TYPE[LANE_W-1:0]
                                                  : ERR_CODE[LANE_W-1:0];
      end
      return v;
   endfunction

   localparam logic [BLK_W-1:0] ERR_PAT = mk_err_pat();

   generate
      if (BLK_W != HDR_W + LANES*LANE_W) begin : g_bad_width
         $error("blk_order_guard: BLK_W must equal HDR_W + LANES*LANE_W");
      end
      if (LANES < 2 || LANE_W < 8) begin : g_bad_lanes
         $error("blk_order_guard: need at least two octet lanes");
      end
      if (HDR_W != 2) begin : g_bad_hdr
         $error("blk_order_guard: sync header must be two bits");
      end
   endgenerate

   blk_cls_e cls_n;
   blk_cls_e st_q;
   blk_cls_e held_cls;
   logic     kill;

   assign cls_n = norm_cls(cls_in);

   bog_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .lock_ok (lock_ok),
      .cls_n   (cls_n),
      .st_q    (st_q),
      .kill    (kill)
   );

   bog_outreg #(
      .BLK_W   (BLK_W),
      .ERR_PAT (ERR_PAT)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .blk_in   (blk_in),
      .cls_n    (cls_n),
      .kill     (kill),
      .held_cls (held_cls),
      .out_blk  (out_blk),
      .out_ctl  (out_ctl),
      .out_err  (out_err)
   );

endmodule

// File: rtl/bog_checker.sv
module bog_checker #(
   parameter int              BLK_W   = 66,
   parameter logic [BLK_W-1:0] ERR_PAT = '0
)(
   input logic             clk,
   input logic             rst_n,
   input logic             lock_ok,
   input logic [2:0]       cls_in,
   input logic [2:0]       st,
   input logic [2:0]       hcls,
   input logic [BLK_W-1:0] out_blk,
   input logic             out_ctl,
   input logic             out_err
);

   localparam logic [2:0] C_Z = 3'd0, C_S = 3'd1, C_D = 3'd2, C_T = 3'd3, C_E = 3'd4;

   p_exit_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == C_E && lock_ok && cls_in == C_Z) |=> (st == C_Z));

   p_nolock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !lock_ok |=> (out_err && st == C_E));

   p_data_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_ok && st == C_D && hcls == C_D && (cls_in == C_D || cls_in == C_T))
      |=> (!out_err && !out_ctl));

   p_term_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == C_T && cls_in != C_Z) |=> (out_err && st == C_E));

   p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == C_E && cls_in != C_Z) |=> (st == C_E && out_err));

   p_start_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st != C_Z && st != C_E && cls_in == C_S) |=> (out_err && st == C_E));

   p_err_shape_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_blk == ERR_PAT && out_ctl));

endmodule

bind blk_order_guard bog_checker #(
   .BLK_W   (BLK_W),
   .ERR_PAT (ERR_PAT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .lock_ok (lock_ok),
   .cls_in  (cls_in),
   .st      (st_q),
   .hcls    (held_cls),
   .out_blk (out_blk),
   .out_ctl (out_ctl),
   .out_err (out_err)
);

// File: tb/blk_order_guard_test.sv
`timescale 1ns/1ps
module blk_order_guard_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lock_ok = 1'b0;
   logic [65:0] blk_in = '0;
   logic [2:0]  cls_in = 3'd4;
   logic [65:0] out_blk;
   logic        out_ctl;
   logic        out_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // Model state: 0=Z 1=S 2=D 3=T 4=E
   int          m_st = 4;
   int          m_hcls = 4;
   logic [65:0] m_hblk = '0;
   int          last_c = 4;

   always #10 clk = ~clk;   // 50 MHz

   blk_order_guard uut (
      .clk(clk), .rst_n(rst_n), .lock_ok(lock_ok), .blk_in(blk_in),
      .cls_in(cls_in), .out_blk(out_blk), .out_ctl(out_ctl), .out_err(out_err)
   );

   function automatic logic [65:0] err_blk();
      logic [65:0] v;
      v = '0;
      v[1:0] = 2'b01;                       // R9 header
      v[9:2] = 8'h1E;                       // R9 type byte
      for (int k = 1; k < 8; k++) v[8*k+2 +: 8] = 8'hFE;
      return v;
   endfunction

   function automatic bit legal(int p, int n);
      case (p)
         0: return (n == 0) || (n == 1);
         1: return (n == 2) || (n == 3);
         2: return (n == 2) || (n == 3);
         3: return (n == 0);
         default: return 0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [65:0] eb, input logic ec, input logic ee);
      n_chk++;
      if (out_blk !== eb || out_ctl !== ec || out_err !== ee) begin
         n_bad++;
         $display("FAIL %s: got blk=%h ctl=%b err=%b, expected blk=%h ctl=%b err=%b",
                  tag, out_blk, out_ctl, out_err, eb, ec, ee);
      end
   endtask

   // Called just after a falling edge: drive, advance the model, check at the next falling edge
   task automatic step(input logic [2:0] c, input logic [65:0] b, input logic lk);
      int cn, ns;
      logic ee, ec;
      logic [65:0] eb;
      string tag;
      cls_in = c; blk_in = b; lock_ok = lk;
      cn = (c > 3) ? 4 : int'(c);
      if (!lk)             ns = 4;
      else if (m_st == 4)  ns = (cn == 0) ? 0 : 4;
      else                 ns = legal(m_st, cn) ? cn : 4;
      ee = (m_st == 4) || (ns == 4);
      eb = ee ? err_blk() : m_hblk;
      ec = ee ? 1'b1 : (m_hcls != 2);
      if (!lk)                                  tag = "R3";
      else if (m_st == 3 && cn != 0)            tag = "R5";
      else if (cn == 1 && m_st != 0 && m_st != 4) tag = "R7";
      else if (m_st == 4 && cn == 0)            tag = "R2";
      else if (m_st == 4)                       tag = "R6";
      else if (ns == 4)                         tag = "R8";
      else                                      tag = "R4";
      m_st = ns; m_hcls = cn; m_hblk = b; last_c = cn;
      @(negedge clk);
      check(tag, eb, ec, ee);
      if (ee) begin
         n_chk++;
         if (out_blk !== err_blk()) begin
            n_bad++;
            $display("FAIL R9: got blk=%h expected %h", out_blk, err_blk());
         end
      end
   endtask

   function automatic logic [65:0] rnd_blk();
      return {$urandom(), $urandom(), 2'($urandom())};
   endfunction

   function automatic logic [2:0] pick_next(int p);
      int r;
      r = $urandom_range(99);
      if (r >= 88) return 3'($urandom_range(7));
      case (p)
         0: return (r < 60) ? 3'd0 : 3'd1;
         1: return (r < 70) ? 3'd2 : 3'd3;
         2: return (r < 75) ? 3'd2 : 3'd3;
         default: return 3'd0;
      endcase
   endfunction

   task automatic seq(input int cs[]);
      foreach (cs[i]) step(3'(cs[i]), rnd_blk(), 1'b1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 in reset", err_blk(), 1'b1, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", err_blk(), 1'b1, 1'b1);
      // R1/R6: lock present but no Z yet
      step(3'd2, rnd_blk(), 1'b1);
      step(3'd1, rnd_blk(), 1'b1);
      // R2 then R4: clean packet Z Z S D D T Z Z
      seq('{0, 0, 1, 2, 2, 3, 0, 0});
      // R5: terminate followed by data
      seq('{1, 3, 2, 0, 0, 0});
      // R7: start after data, start after terminate
      seq('{1, 2, 1, 2, 3, 0, 0, 1, 3, 1, 0, 0});
      // R8: invalid codes 4..7 inside a packet, D straight after Z
      seq('{1, 2, 7, 5, 0, 0, 2, 0, 0, 0});
      // R3: lock drop mid packet, then recovery
      seq('{1, 2});
      step(3'd2, rnd_blk(), 1'b0);
      step(3'd0, rnd_blk(), 1'b0);
      seq('{0, 0, 1, 3, 0, 0});
      // R6: long run without Z
      seq('{2, 3, 1, 6, 2, 0, 0});
      // Constrained random ordering with rare lock loss
      for (int i = 0; i < 4000; i++) begin
         step(pick_next(last_c), rnd_blk(), ($urandom_range(99) != 0));
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

endmodule